// File: doc/BRIEF.md
# Return-to-Zero to Transition Handshake Bridge

This block carries data words from a sender that uses a four-phase, return-to-zero request/acknowledge handshake to a receiver that uses a two-phase, transition-signalled handshake. Every handshake wire is sampled by one local clock. This keeps the bridge an ordinary synchronous block. It can sit between a level-signalling producer and a toggle-signalling consumer that share the same clock.

On the four-phase side, one item moves through four events in order: request goes high, acknowledge goes high, request goes low, acknowledge goes low. On the two-phase side, each item costs exactly two wire events. The bridge flips its request once, and the receiver answers by flipping its acknowledge once. The bridge captures the word when it first sees the four-phase request high. It shows the word on its output bus one clock before it flips the two-phase request. It raises the four-phase acknowledge only after the receiver has answered.

A sticky flag records a sender that lets go of its request too early. A wrapping counter records how many items the receiver has confirmed.

Top module: `hs_rtz_nrz_bridge`

## Requirements
- R1: During and right after synchronous active-low reset, `up_ack`, `dn_req`, `proto_err` and `xfer_cnt` are all 0. A wire pair `dn_req`/`dn_ack` with equal levels means the two-phase side is idle.
- R2: The word on `up_data` in the clock where the bridge first samples `up_req` high while idle is the word shown on `dn_data` when `dn_req` next toggles.
- R3: For each accepted item, `dn_req` toggles exactly once, one clock after the capture clock. A request held high while the receiver is slow causes no further toggle.
- R4: While `dn_req` differs from `dn_ack`, `dn_data` does not change.
- R5: While an item is outstanding (`dn_req` differs from `dn_ack`), `up_ack` stays 0. It rises on the clock edge that samples `dn_ack` equal to `dn_req`.
- R6: Once high, `up_ack` stays high for as long as `up_req` is high. It falls on the first clock edge that samples `up_req` low.
- R7: While `up_ack` is high, `dn_req` does not toggle. No new item is accepted until `up_ack` has returned to 0.
- R8: If `up_req` is sampled low after capture but before `up_ack` has risen, `proto_err` becomes 1 and stays 1 until reset. The captured item is still delivered and acknowledged.
- R9: `xfer_cnt` increases by one, modulo 2^CNT_W, on the same edge where `up_ack` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples all handshake wires |
| rst_n | input | 1 | Synchronous reset, active low |
| up_req | input | 1 | Four-phase request from the sender |
| up_ack | output | 1 | Four-phase acknowledge to the sender |
| up_data | input | DATA_W | Word from the sender, held stable while up_req is high |
| dn_req | output | 1 | Two-phase request; each toggle announces one item |
| dn_ack | input | 1 | Two-phase acknowledge; each toggle confirms one item |
| dn_data | output | DATA_W | Word offered to the receiver |
| proto_err | output | 1 | Sticky flag: request dropped before acknowledge |
| xfer_cnt | output | CNT_W | Wrapping count of confirmed items |

## Verification
The hardest case to reach from the ports is a sender that drops its request while an item is still in flight. A sender that obeys the protocol never does this. The stimulus raises the request for one clock and lowers it on the next, while the receiver model is set to answer slowly. The item is therefore still outstanding when the request falls. The bench then checks that the flag sets, that the word still arrives, and that a later well-formed item passes with the flag still held. A second hard case is holding the acknowledge high across a long request. The driver keeps the request high for several extra clocks and watches that the two-phase request does not move.

// File: rtl/hsb_pkg.sv
// Package for the handshake bridge.
// Holds the controller state type shared by the bridge modules.
package hsb_pkg;

    // Four-phase controller states, in the order one item moves through them.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // no item held; watching for request high
        ST_LAUNCH = 2'd1,   // word captured; toggle goes out on the next edge
        ST_WAIT   = 2'd2,   // toggle sent; waiting for receiver answer
        ST_HOLD   = 2'd3    // acknowledge high; waiting for request low
    } hsb_state_t;

endpackage

// File: rtl/hsb_xfer_cnt.sv
// Wrapping event counter.
// Counts single-cycle pulses on inc. Assumes inc is at most one cycle wide per event.
module hsb_xfer_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Step the count on each pulse; wraps naturally at 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/hsb_nrz_tx.sv
// Two-phase transmit side.
// Holds the captured word and the toggling request wire.
// Assumes: cap and launch are single-cycle pulses from the controller, and launch
// follows cap by one clock. The receiver toggles dn_ack only in answer to a request.
module hsb_nrz_tx #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              launch,
    input  logic [DATA_W-1:0] din,
    input  logic              dn_ack,
    output logic              dn_req,
    output logic [DATA_W-1:0] dn_data,
    output logic              nrz_idle
);

    logic [DATA_W-1:0] hold_q;
    logic              req_q;

    // Capture the sender's word in the clock where the request is first seen.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else if (cap) hold_q <= din;
    end

    // One toggle per item; the word has already been on the bus for a clock.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else if (launch) req_q <= ~req_q;
    end

    assign dn_req   = req_q;
    assign dn_data  = hold_q;
    assign nrz_idle = (req_q == dn_ack);

    // R4: the offered word holds still while the receiver has not answered
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != dn_ack) |=> $stable(hold_q));

endmodule

// File: rtl/hsb_rtz_ctrl.sv
// Four-phase side controller.
// Steps an item through capture, launch, wait-for-answer and return-to-zero.
// It raises the sender acknowledge, counts confirmed items and flags early request drop.
// Assumes all inputs are synchronous to clk.
module hsb_rtz_ctrl
    import hsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic nrz_idle,
    output logic up_ack,
    output logic cap,
    output logic launch,
    output logic done,
    output logic err
);

    hsb_state_t state_q;
    logic       ack_q;
    logic       err_q;

    // Decode the single-cycle actions from the current state.
    always_comb begin
        cap    = (state_q == ST_IDLE) && up_req;
        launch = (state_q == ST_LAUNCH);
        done   = (state_q == ST_WAIT) && nrz_idle;
    end

    // Walk one item through its four-phase sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE:   if (up_req) state_q <= ST_LAUNCH;
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT:   if (nrz_idle) begin
                               state_q <= ST_HOLD;
                               ack_q   <= 1'b1;
                           end
                ST_HOLD:   if (!up_req) begin
                               state_q <= ST_IDLE;
                               ack_q   <= 1'b0;
                           end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch a request withdrawn while the item is still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (!up_req && (state_q == ST_LAUNCH || state_q == ST_WAIT)) err_q <= 1'b1;
    end

    assign up_ack = ack_q;
    assign err    = err_q;

    // R5: acknowledge rises only after the receiver's answer was seen
    a_r5_ack_after_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(nrz_idle));

    // R6: acknowledge falls only after the request was seen low
    a_r6_ack_falls_on_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> $past(!up_req));

    // R6: acknowledge holds while the request stays high
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && up_req) |=> ack_q);

    // R8: the error flag never clears outside reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/hs_rtz_nrz_bridge.sv
// Bridge from a four-phase return-to-zero sender to a two-phase toggle receiver.
// All handshake wires are sampled on clk; no synchronizers are included, so both
// parties must be synchronous to clk. The sender holds up_data stable while up_req is high.
module hs_rtz_nrz_bridge #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    output logic              up_ack,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_req,
    input  logic              dn_ack,
    output logic [DATA_W-1:0] dn_data,
    output logic              proto_err,
    output logic [CNT_W-1:0]  xfer_cnt
);

    logic cap, launch, done, nrz_idle;

    hsb_rtz_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_req   (up_req),
        .nrz_idle (nrz_idle),
        .up_ack   (up_ack),
        .cap      (cap),
        .launch   (launch),
        .done     (done),
        .err      (proto_err)
    );

    hsb_nrz_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .launch   (launch),
        .din      (up_data),
        .dn_ack   (dn_ack),
        .dn_req   (dn_req),
        .dn_data  (dn_data),
        .nrz_idle (nrz_idle)
    );

    hsb_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (done),
        .cnt   (xfer_cnt)
    );

    // R3: a request toggle is always preceded by a sampled request two clocks back
    a_r3_toggle_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req != $past(dn_req)) |-> $past(up_req, 2));

    // R7: no new toggle while the sender still sees acknowledge high
    a_r7_no_toggle_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> $stable(dn_req));

    // R9: the count steps by one on the acknowledge rise
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> (xfer_cnt == CNT_W'($past(xfer_cnt) + 1'b1)));

endmodule

// File: tb/tb_hs_rtz_nrz_bridge.sv
module tb_hs_rtz_nrz_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0;
    logic          up_ack;
    logic [DW-1:0] up_data = '0;
    logic          dn_req;
    logic          dn_ack = 1'b0;
    logic [DW-1:0] dn_data;
    logic          proto_err;
    logic [CW-1:0] xfer_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int sent     = 0;
    int toggles  = 0;
    int rx_delay = 0;
    logic [DW-1:0] exp_q[$];

    hs_rtz_nrz_bridge #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack), .up_data(up_data),
        .dn_req(dn_req), .dn_ack(dn_ack), .dn_data(dn_data),
        .proto_err(proto_err), .xfer_cnt(xfer_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Count every dn_req edge seen at the sampling point (R3).
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && dn_req != prev) toggles++;
            prev = dn_req;
        end
    end

    // Receiver model and scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dn_req != dn_ack) begin
                logic [DW-1:0] e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected item", 32'(dn_data), 32'hx);
                    e = dn_data;
                end else begin
                    e = exp_q.pop_front();
                    chk(dn_data == e, "R2 word", 32'(dn_data), 32'(e));
                end
                for (int i = 0; i < rx_delay; i++) begin
                    @(negedge clk);
                    chk(dn_data == e, "R4 word stable", 32'(dn_data), 32'(e));
                    chk(up_ack == 1'b0, "R5 ack low while outstanding", 32'(up_ack), 0);
                end
                dn_ack = ~dn_ack;
                @(negedge clk);
                chk(up_ack == 1'b1, "R5 ack after answer", 32'(up_ack), 1);
            end
        end
    end

    // Driver: one well-formed four-phase item, request held hold extra clocks after ack.
    task automatic send(input logic [DW-1:0] d, input int hold);
        logic r;
        up_data = d;
        up_req  = 1'b1;
        exp_q.push_back(d);
        sent++;
        while (!up_ack) @(negedge clk);
        r = dn_req;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(up_ack == 1'b1, "R6 ack held", 32'(up_ack), 1);
            chk(dn_req == r, "R7 no toggle in hold", 32'(dn_req), 32'(r));
        end
        up_req = 1'b0;
        @(negedge clk);
        chk(up_ack == 1'b0, "R6 ack falls", 32'(up_ack), 0);
        up_data = ~d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(up_ack == 0 && dn_req == 0 && proto_err == 0 && xfer_cnt == 0,
            "R1 reset state", {29'd0, up_ack, dn_req, proto_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(up_ack == 0 && dn_req == 0 && dn_ack == 0 && xfer_cnt == 0,
            "R1 after release", {30'd0, up_ack, dn_req}, 0);

        // R2/R3/R9: fast receiver, varied words
        rx_delay = 0;
        send(16'h0000, 0);
        send(16'hFFFF, 0);
        send(16'hA5A5, 0);
        send(16'h5A5A, 1);
        for (int k = 0; k < 6; k++) send(16'(16'h1234 * (k + 3)), 0);

        // R4/R5/R6/R7: slow receiver, request held long
        rx_delay = 3;
        send(16'hBEEF, 4);
        send(16'h0F0F, 2);
        chk(proto_err == 1'b0, "R8 no error on clean traffic", 32'(proto_err), 0);

        // R8: request dropped while item in flight
        rx_delay = 4;
        up_data = 16'hC0DE;
        up_req  = 1'b1;
        exp_q.push_back(16'hC0DE);
        sent++;
        @(negedge clk);
        up_req = 1'b0;
        while (!up_ack) @(negedge clk);
        @(negedge clk);
        chk(up_ack == 1'b0, "R8 ack returns", 32'(up_ack), 0);
        chk(proto_err == 1'b1, "R8 error set", 32'(proto_err), 1);
        rx_delay = 1;
        send(16'h7777, 0);
        send(16'h8888, 0);
        send(16'h9999, 0);
        send(16'hAAAA, 0);
        send(16'hBBBB, 0);
        chk(proto_err == 1'b1, "R8 error sticky", 32'(proto_err), 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all items delivered", 32'(exp_q.size()), 0);
        chk(toggles == sent, "R3 one toggle per item", 32'(toggles), 32'(sent));
        chk(xfer_cnt == CW'(sent), "R9 count wraps", 32'(xfer_cnt), 32'(CW'(sent)));

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule